// File: doc/BRIEF.md
# Display-RAM Contention Clock Gate

This block sits between a CPU and the lower 16K of RAM that holds the display area. The RAM is also read by a video fetch engine. The block takes the 14 MHz master clock and divides it by four to make the CPU clock. One period of that clock is called a T-state. A raster counter inside the block runs on T-states and decides which T-states belong to the video engine. During an active display line, each group of 8 T-states starts with 6 fetch T-states (`vid_fetch` high).

The CPU may start a T-state with a memory request into the display window or with an I/O request whose A0 is low. If that T-state is a fetch T-state, the block does not insert wait states. It freezes the CPU clock high for the whole T-state instead. It repeats this for each following fetch T-state. The CPU then resumes in the first T-state the engine leaves free. The block also decodes the ROM chip select from the request and the top address bits.

Control is a two-state machine:
- `ST_RUN`: the clock toggles.
- `ST_HOLD`: the clock is frozen high.

It changes state only at a T-state boundary. The transitions are:
- RUN→HOLD: a contended request is pending as a fetch T-state begins.
- HOLD→HOLD: the request is still pending and the next T-state is also a fetch T-state.
- HOLD→RUN: the next T-state is free.
- RUN→RUN: every other case.

Top module: `vid_contend_clkgate`

## Requirements
- R1: With no freeze, `cpu_clk` has a period of 4 master cycles. It is high in phases 0 and 1 of a T-state and low in phases 2 and 3.
- R2: The raster has 224 T-states per line and 312 lines per frame, both as defaults. `vid_fetch` is high in T-state h of line v exactly when h < 128, v < 192 and h mod 8 < 6.
- R3: A memory request (`cpu_mreq_n` low) with address bits 15:14 = 01 that is present as a fetch T-state begins freezes `cpu_clk` high for that entire T-state.
- R4: An I/O request (`cpu_iorq_n` low) with address bit 0 = 0 is held off in the same way as R3.
- R5: The following requests never freeze the clock: an I/O request with address bit 0 = 1, and a memory request with address bits 15:14 other than 01.
- R6: No freeze happens outside the active area, that is when h ≥ 128 or v ≥ 192. This includes the frame wrap back to line 0.
- R7: The freeze decision is taken only at a T-state boundary. While the clock is frozen it stays high in all four phases.
- R8: `rom_cs_n` is low exactly when `cpu_mreq_n` is low and address bits 15:14 = 00. It is combinational.
- R9: During reset the following hold: the raster is at line 0, T-state 0, phase 0; the state is `ST_RUN`; `cpu_clk` is high; and `rom_cs_n` is high when no request is present.
- R10: The number of frozen T-states equals the number of consecutive fetch T-states from the first requested one. For example, the count is 6 at slot offset 0, 3 at offset 3, 1 at offset 5 and 0 at offset 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mst | input | 1 | 14 MHz master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_mreq_n | input | 1 | CPU memory request, active low |
| cpu_iorq_n | input | 1 | CPU I/O request, active low |
| cpu_clk | output | 1 | Gated CPU clock, frozen high when held |
| rom_cs_n | output | 1 | ROM chip select, active low |
| vid_fetch | output | 1 | Video engine owns the display RAM in the current T-state |

## Verification
The hardest case to reach is a freeze whose length depends on exactly where in an 8-T-state slot the request lands. Nearby cases are a request that lands on the last fetch T-state of a line, and one that lands on the first line after the frame wraps. The bench keeps its own master-cycle count from reset release, so it knows the raster position of every T-state. It raises each request two master cycles before a chosen boundary and releases it in the first T-state that runs. The bench shortens the frame to four lines so that the vertical blanking and the wrap are reached quickly.

// File: rtl/vcg_pkg.sv
package vcg_pkg;
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } hold_state_e;
endpackage

// File: rtl/vcg_phase.sv
// Master-clock phase counter: one wrap per CPU T-state.
module vcg_phase #(
    parameter int CLK_DIV = 4,
    localparam int PW = $clog2(CLK_DIV)
) (
    input  logic          clk_mst,
    input  logic          rst_n,
    output logic [PW-1:0] ph,
    output logic          tick,
    output logic          hi_phase
);
    localparam logic [PW-1:0] PH_LAST = PW'(CLK_DIV - 1);
    localparam logic [PW-1:0] PH_HALF = PW'(CLK_DIV / 2);

    always_ff @(posedge clk_mst) begin
        if (!rst_n)
            ph <= '0;
        else if (ph == PH_LAST)
            ph <= '0;
        else
            ph <= ph + 1'b1;
    end

    assign tick     = (ph == PH_LAST);
    assign hi_phase = (ph < PH_HALF);
endmodule

// File: rtl/vcg_raster.sv
// T-state raster counter and fetch-slot schedule.
module vcg_raster #(
    parameter int H_TOTAL   = 224,
    parameter int H_ACTIVE  = 128,
    parameter int V_TOTAL   = 312,
    parameter int V_ACTIVE  = 192,
    parameter int SLOT_LEN  = 8,
    parameter int FETCH_LEN = 6,
    localparam int HW = $clog2(H_TOTAL),
    localparam int VW = $clog2(V_TOTAL)
) (
    input  logic          clk_mst,
    input  logic          rst_n,
    input  logic          tick,
    output logic [HW-1:0] h_pos,
    output logic [VW-1:0] v_pos,
    output logic          busy_cur,
    output logic          busy_nxt
);
    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
    localparam logic [HW-1:0] H_ACT  = HW'(H_ACTIVE);
    localparam logic [VW-1:0] V_ACT  = VW'(V_ACTIVE);
    localparam logic [HW-1:0] SLOT   = HW'(SLOT_LEN);
    localparam logic [HW-1:0] FETCH  = HW'(FETCH_LEN);

    logic [HW-1:0] h_nxt;
    logic [VW-1:0] v_nxt;

    function automatic logic slot_busy(input logic [HW-1:0] h, input logic [VW-1:0] v);
        return (h < H_ACT) && (v < V_ACT) && ((h % SLOT) < FETCH);
    endfunction

    always_comb begin
        h_nxt = (h_pos == H_LAST) ? '0 : h_pos + 1'b1;
        v_nxt = v_pos;
        if (h_pos == H_LAST)
            v_nxt = (v_pos == V_LAST) ? '0 : v_pos + 1'b1;
    end

    always_ff @(posedge clk_mst) begin
        if (!rst_n) begin
            h_pos <= '0;
            v_pos <= '0;
        end else if (tick) begin
            h_pos <= h_nxt;
            v_pos <= v_nxt;
        end
    end

    assign busy_cur = slot_busy(h_pos, v_pos);
    assign busy_nxt = slot_busy(h_nxt, v_nxt);
endmodule

// File: rtl/vcg_hold_fsm.sv
// RUN/HOLD machine deciding, per T-state, whether the CPU clock toggles.
module vcg_hold_fsm
    import vcg_pkg::*;
(
    input  logic        clk_mst,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        contend_req,
    input  logic        busy_nxt,
    input  logic        hi_phase,
    output hold_state_e state,
    output logic        cpu_clk
);
    hold_state_e state_nxt;

    always_ff @(posedge clk_mst) begin
        if (!rst_n)
            state <= ST_RUN;
        else
            state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN: begin
                if (tick && contend_req && busy_nxt)
                    state_nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (tick && !(contend_req && busy_nxt))
                    state_nxt = ST_RUN;
            end
        endcase
    end

    always_comb begin
        unique case (state)
            ST_RUN:  cpu_clk = hi_phase;
            ST_HOLD: cpu_clk = 1'b1;
        endcase
    end
endmodule

// File: rtl/vid_contend_clkgate.sv
module vid_contend_clkgate
    import vcg_pkg::*;
#(
    parameter int CLK_DIV   = 4,
    parameter int H_TOTAL   = 224,
    parameter int H_ACTIVE  = 128,
    parameter int V_TOTAL   = 312,
    parameter int V_ACTIVE  = 192,
    parameter int SLOT_LEN  = 8,
    parameter int FETCH_LEN = 6
) (
    input  logic        clk_mst,
    input  logic        rst_n,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_mreq_n,
    input  logic        cpu_iorq_n,
    output logic        cpu_clk,
    output logic        rom_cs_n,
    output logic        vid_fetch
);
    localparam int PW = $clog2(CLK_DIV);
    localparam int HW = $clog2(H_TOTAL);
    localparam int VW = $clog2(V_TOTAL);

    logic [PW-1:0] ph_q;
    logic          tick;
    logic          hi_phase;
    logic [HW-1:0] h_q;
    logic [VW-1:0] v_q;
    logic          busy_nxt;
    logic          contend_req;
    logic          held;
    hold_state_e   state;
    logic          unused_addr_bits;

    assign unused_addr_bits = ^cpu_addr[13:1];

    // Display-window memory access or even-port I/O contends with the fetch engine.
    assign contend_req = (!cpu_mreq_n && (cpu_addr[15:14] == 2'b01))
                       || (!cpu_iorq_n && !cpu_addr[0]);
    assign rom_cs_n    = !(!cpu_mreq_n && (cpu_addr[15:14] == 2'b00));
    assign held        = (state == ST_HOLD);

    vcg_phase #(.CLK_DIV(CLK_DIV)) u_phase (
        .clk_mst  (clk_mst),
        .rst_n    (rst_n),
        .ph       (ph_q),
        .tick     (tick),
        .hi_phase (hi_phase)
    );

    vcg_raster #(
        .H_TOTAL(H_TOTAL), .H_ACTIVE(H_ACTIVE),
        .V_TOTAL(V_TOTAL), .V_ACTIVE(V_ACTIVE),
        .SLOT_LEN(SLOT_LEN), .FETCH_LEN(FETCH_LEN)
    ) u_raster (
        .clk_mst  (clk_mst),
        .rst_n    (rst_n),
        .tick     (tick),
        .h_pos    (h_q),
        .v_pos    (v_q),
        .busy_cur (vid_fetch),
        .busy_nxt (busy_nxt)
    );

    vcg_hold_fsm u_fsm (
        .clk_mst     (clk_mst),
        .rst_n       (rst_n),
        .tick        (tick),
        .contend_req (contend_req),
        .busy_nxt    (busy_nxt),
        .hi_phase    (hi_phase),
        .state       (state),
        .cpu_clk     (cpu_clk)
    );
endmodule

// File: rtl/vcg_checker.sv
module vcg_checker #(
    parameter int PW = 2,
    parameter int HW = 8,
    parameter int VW = 9,
    parameter int H_ACTIVE = 128,
    parameter int V_ACTIVE = 192
) (
    input logic          clk_mst,
    input logic          rst_n,
    input logic          cpu_clk,
    input logic          vid_fetch,
    input logic          rom_cs_n,
    input logic          cpu_mreq_n,
    input logic [15:0]   cpu_addr,
    input logic          held,
    input logic          creq,
    input logic [PW-1:0] ph,
    input logic [HW-1:0] h_pos,
    input logic [VW-1:0] v_pos
);
    localparam logic [HW-1:0] H_ACT = HW'(H_ACTIVE);
    localparam logic [VW-1:0] V_ACT = VW'(V_ACTIVE);

    AST_CLK_HIGH_PHASE0: assert property (@(posedge clk_mst) disable iff (!rst_n)
        (ph == '0) |-> cpu_clk);                                                  // R1
    AST_CLK_LOW_WHEN_RUN: assert property (@(posedge clk_mst) disable iff (!rst_n)
        (!held && ph[PW-1]) |-> !cpu_clk);                                        // R1
    AST_FETCH_IN_ACTIVE: assert property (@(posedge clk_mst) disable iff (!rst_n)
        vid_fetch |-> ((h_pos < H_ACT) && (v_pos < V_ACT)));                      // R2
    AST_HOLD_ONLY_IN_FETCH: assert property (@(posedge clk_mst) disable iff (!rst_n)
        held |-> vid_fetch);                                                      // R6
    AST_HELD_CLK_HIGH: assert property (@(posedge clk_mst) disable iff (!rst_n)
        held |-> cpu_clk);                                                        // R7
    AST_STATE_ON_BOUNDARY: assert property (@(posedge clk_mst) disable iff (!rst_n)
        (ph != '0) |-> $stable(held));                                            // R7
    AST_NO_REQ_NO_HOLD: assert property (@(posedge clk_mst) disable iff (!rst_n)
        ((ph == '0) && !$past(creq)) |-> !held);                                  // R5
    AST_ROM_SELECT: assert property (@(posedge clk_mst) disable iff (!rst_n)
        !rom_cs_n |-> (!cpu_mreq_n && (cpu_addr[15:14] == 2'b00)));               // R8
endmodule

bind vid_contend_clkgate vcg_checker #(
    .PW(PW), .HW(HW), .VW(VW), .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE)
) u_chk (
    .clk_mst    (clk_mst),
    .rst_n      (rst_n),
    .cpu_clk    (cpu_clk),
    .vid_fetch  (vid_fetch),
    .rom_cs_n   (rom_cs_n),
    .cpu_mreq_n (cpu_mreq_n),
    .cpu_addr   (cpu_addr),
    .held       (held),
    .creq       (contend_req),
    .ph         (ph_q),
    .h_pos      (h_q),
    .v_pos      (v_q)
);

// File: tb/vid_contend_clkgate_tb_top.sv
`timescale 1ns/1ps
module vid_contend_clkgate_tb_top;
    localparam int HT = 224;
    localparam int HA = 128;
    localparam int VT = 4;
    localparam int VA = 2;

    typedef struct packed {
        logic [15:0] t0;
        logic [15:0] addr;
        logic        is_io;
        logic [3:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{16'd8,   16'h4000, 1'b0, 4'd6, 4'd3},   // R3 slot offset 0
        '{16'd19,  16'h5800, 1'b0, 4'd3, 4'd10},  // R10 offset 3
        '{16'd30,  16'h4000, 1'b0, 4'd0, 4'd10},  // R10 offset 6
        '{16'd37,  16'h7FFF, 1'b0, 4'd1, 4'd10},  // R10 offset 5
        '{16'd44,  16'h8000, 1'b0, 4'd0, 4'd5},   // R5 upper RAM
        '{16'd48,  16'h00FE, 1'b1, 4'd6, 4'd4},   // R4 even port
        '{16'd64,  16'h00FF, 1'b1, 4'd0, 4'd5},   // R5 odd port
        '{16'd72,  16'hC000, 1'b0, 4'd0, 4'd5},   // R5 top RAM
        '{16'd124, 16'h4000, 1'b0, 4'd2, 4'd10},  // R10 last slot of line
        '{16'd160, 16'h4000, 1'b0, 4'd0, 4'd6},   // R6 horizontal border
        '{16'd226, 16'h6000, 1'b0, 4'd4, 4'd3},   // R3 line 1 offset 2
        '{16'd448, 16'h4000, 1'b0, 4'd0, 4'd6},   // R6 vertical border
        '{16'd904, 16'h4000, 1'b0, 4'd6, 4'd6}    // R6 frame wrap, line 0 again
    };

    logic        clk_mst = 1'b0;
    logic        rst_n   = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_mreq_n = 1'b1;
    logic        cpu_iorq_n = 1'b1;
    logic        cpu_clk, rom_cs_n, vid_fetch;

    int unsigned mc = 0;
    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk_mst = ~clk_mst;

    always @(posedge clk_mst) begin
        if (!rst_n) mc <= 0;
        else        mc <= mc + 1;
    end

    vid_contend_clkgate #(
        .H_TOTAL(HT), .H_ACTIVE(HA), .V_TOTAL(VT), .V_ACTIVE(VA)
    ) dut_i (
        .clk_mst(clk_mst), .rst_n(rst_n), .cpu_addr(cpu_addr),
        .cpu_mreq_n(cpu_mreq_n), .cpu_iorq_n(cpu_iorq_n),
        .cpu_clk(cpu_clk), .rom_cs_n(rom_cs_n), .vid_fetch(vid_fetch)
    );

    function automatic bit model_busy(input int unsigned t);
        int unsigned h = t % HT;
        int unsigned v = (t / HT) % VT;
        return (h < HA) && (v < VA) && ((h % 8) < 6);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (mc=%0d)", req, act, exp, mc);
        end
    endtask

    task automatic goto_mc(input int unsigned target);
        if (mc > target) check("sched", int'(mc), int'(target));
        while (mc < target) @(negedge clk_mst);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk_mst);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk_mst);
        // R9: reset state
        check("R9 cpu_clk", cpu_clk, 1);
        check("R9 rom_cs_n", rom_cs_n, 1);
        check("R9 vid_fetch", vid_fetch, 1);
        rst_n = 1'b1;

        // R1: free-running clock in T-state 1
        for (int p = 0; p < 4; p++) begin
            goto_mc(4 + p);
            check("R1 cpu_clk phase", cpu_clk, (p < 2) ? 1 : 0);
        end

        // R8: ROM select decode
        goto_mc(9);
        cpu_mreq_n = 1'b0; cpu_addr = 16'h1234; #1;
        check("R8 rom low", rom_cs_n, 0);
        cpu_addr = 16'h8000; #1;
        check("R8 rom high A15", rom_cs_n, 1);
        cpu_mreq_n = 1'b1; cpu_addr = 16'h0000; #1;
        check("R8 rom no mreq", rom_cs_n, 1);
        cpu_iorq_n = 1'b0; cpu_addr = 16'h0001; #1;
        check("R8 rom io", rom_cs_n, 1);
        cpu_iorq_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            int unsigned t;
            int frozen;
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            goto_mc(4 * (int'(VECS[i].t0) - 1) + 1);
            check("R2 vid_fetch", vid_fetch, model_busy(VECS[i].t0 - 1));
            cpu_addr = VECS[i].addr;
            if (VECS[i].is_io) cpu_iorq_n = 1'b0;
            else               cpu_mreq_n = 1'b0;
            t = VECS[i].t0;
            frozen = 0;
            forever begin
                goto_mc(4 * t + 2);
                if (!cpu_clk) break;
                // R7: frozen T-state stays high in its last phase too
                goto_mc(4 * t + 3);
                check("R7 frozen high", cpu_clk, 1);
                frozen++;
                t++;
                if (frozen > 12) break;
            end
            cpu_mreq_n = 1'b1;
            cpu_iorq_n = 1'b1;
            check(tag, frozen, int'(VECS[i].exp));
        end
        summary();
    end
endmodule